// File: doc/BRIEF.md
# DC-Balance Word Inversion Encoder

This block sits in front of the serializer of one lane. Each clock cycle it may accept a parallel data word. It then decides whether that word goes onto the lane as it is or with every bit flipped. A flag bit goes out with the word and tells the far end which choice was made, so the far end can undo it. The choice keeps the long-term count of ones and zeros on the line close to even. The flag bit is counted as part of the transmitted symbol.

The encoder keeps a signed running disparity. This is the sum of (ones minus zeros) over every symbol sent so far, including each flag bit. The sum is clamped to the range −6 to +7. A synchronous reset loads a caller-supplied starting value. Input words are qualified by a valid strobe. The output word, the flag and the output valid are registered and appear one cycle after the input. A small decoder in the bench flips the word back whenever the flag is set.

Top module: `bal_enc`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous cycle. Each accepted word appears on the outputs exactly one clock after it was presented.
- R2: When `out_flag` is 0, `out_data` equals the accepted word. When `out_flag` is 1, `out_data` is the bitwise complement of that word.
- R3: If the running disparity is exactly 0 when a word is accepted, the word is sent inverted (`out_flag` = 1), whatever its content.
- R4: If the running disparity is above 0, the word is inverted exactly when its disparity is above 0. Word disparity is the count of ones minus the count of zeros, over `DATA_W` bits.
- R5: If the running disparity is below 0, the word is inverted exactly when its disparity is 0 or below.
- R6: After a word is sent as it is, the running disparity changes by (word disparity − 1). After a word is sent inverted, it changes by (1 − word disparity).
- R7: The running disparity never goes above +7 or below −6. A result beyond either bound is replaced by that bound.
- R8: While `rst` is high at a clock edge, `out_valid`, `out_data` and `out_flag` are cleared. The running disparity is loaded from `init_rd`, read as two's complement and clamped to the range −6 to +7.
- R9: A cycle with `in_valid` low leaves the running disparity unchanged and keeps `out_data` and `out_flag` at their previous values, whatever `in_data` holds.
- R10: A symbol passed through the matching decoder gives back the original word. The decoder XORs the word with its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_rd | input | RD_W | Starting running disparity loaded during reset (signed) |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | DATA_W | Word to be sent |
| out_valid | output | 1 | Registered valid for the output symbol |
| out_data | output | DATA_W | Word as sent, either as it is or complemented |
| out_flag | output | 1 | Balance flag: 1 when `out_data` is complemented |

## Verification
The bound checker covers several behaviours on every cycle. These are the one-cycle valid timing, the link between the flag and the data, the inversion choice for zero, positive and negative running disparity, the hold during idle cycles, and the clamp range of the running disparity. The exact arithmetic of the update step, the clamping of an out-of-range reset load, and true saturation are shown only by the bench scenarios. True saturation cannot be reached from a legal state at the default 6-bit width, so the bench uses a second, 8-bit instance for it. These scenarios read later flag decisions at the ports, together with the random sequences that go through the decoder.

// File: rtl/bal_pkg.sv
package bal_pkg;

  // Inversion choice from the signs of the running and word disparity.
  function automatic logic pick_invert(input logic rd_zero,
                                       input logic rd_pos,
                                       input logic d_pos);
    if (rd_zero)
      return 1'b1;
    else if (rd_pos)
      return d_pos;
    else
      return !d_pos;
  endfunction

  // Clamp an integer into [lo, hi].
  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v > hi)
      return hi;
    else if (v < lo)
      return lo;
    else
      return v;
  endfunction

endpackage

// File: rtl/bal_popdisp.sv
module bal_popdisp #(
  parameter int DATA_W = 6,
  localparam int CW = $clog2(DATA_W + 1),
  localparam int DW = CW + 2
) (
  input  logic [DATA_W-1:0]    din,
  output logic signed [DW-1:0] wdisp
);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++)
      ones = ones + CW'(din[i]);
  end

  // ones - zeros = 2*ones - DATA_W
  assign wdisp = $signed({1'b0, ones, 1'b0}) - $signed(DW'(DATA_W));

endmodule

// File: rtl/bal_decide.sv
module bal_decide #(
  parameter int RD_W   = 4,
  parameter int DW     = 5,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input  logic signed [RD_W-1:0] rd_cur,
  input  logic signed [DW-1:0]   wdisp,
  output logic                   invert,
  output logic signed [RD_W-1:0] rd_nxt
);

  logic rd_zero, rd_pos, d_pos;
  int   rd_i, d_i, step_i, sum_i;

  assign rd_zero = ~|rd_cur;
  assign rd_pos  = !rd_cur[RD_W-1] && !rd_zero;
  assign d_pos   = !wdisp[DW-1] && (|wdisp);

  assign invert = bal_pkg::pick_invert(rd_zero, rd_pos, d_pos);

  assign rd_i   = int'(rd_cur);
  assign d_i    = int'(wdisp);
  assign step_i = invert ? (1 - d_i) : (d_i - 1);
  assign sum_i  = bal_pkg::clamp_int(rd_i + step_i, RD_MIN, RD_MAX);
  assign rd_nxt = RD_W'(sum_i);

endmodule

// File: rtl/bal_enc.sv
module bal_enc #(
  parameter int DATA_W = 6,
  parameter int RD_W   = 4,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6,
  localparam int DW    = $clog2(DATA_W + 1) + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [RD_W-1:0] init_rd,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_data,
  output logic                   out_flag
);

  logic signed [RD_W-1:0] rd_q;
  logic signed [RD_W-1:0] rd_nx;
  logic signed [RD_W-1:0] rd_load;
  logic signed [DW-1:0]   wdisp;
  logic                   inv;

  bal_popdisp #(.DATA_W(DATA_W)) u_pop (
    .din   (in_data),
    .wdisp (wdisp)
  );

  bal_decide #(
    .RD_W   (RD_W),
    .DW     (DW),
    .RD_MAX (RD_MAX),
    .RD_MIN (RD_MIN)
  ) u_dec (
    .rd_cur (rd_q),
    .wdisp  (wdisp),
    .invert (inv),
    .rd_nxt (rd_nx)
  );

  assign rd_load = RD_W'(bal_pkg::clamp_int(int'(init_rd), RD_MIN, RD_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= rd_load;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rd_q     <= rd_nx;
        out_data <= in_data ^ {DATA_W{inv}};
        out_flag <= inv;
      end
    end
  end

endmodule

// File: rtl/bal_enc_chk.sv
module bal_enc_chk #(
  parameter int DATA_W = 6,
  parameter int RD_W   = 4,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [DATA_W-1:0]      in_data,
  input logic                   out_valid,
  input logic [DATA_W-1:0]      out_data,
  input logic                   out_flag,
  input logic signed [RD_W-1:0] rd_q
);

  int   ones;
  int   rd_i;
  logic rd_pos, rd_neg, rd_zero, d_pos;

  assign ones    = $countones(in_data);
  assign rd_i    = int'(rd_q);
  assign rd_zero = (rd_i == 0);
  assign rd_pos  = (rd_i > 0);
  assign rd_neg  = (rd_i < 0);
  assign d_pos   = (2 * ones > DATA_W);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  payload_match_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_data == ($past(in_data) ^ {DATA_W{out_flag}})));

  // R3
  zero_rd_invert_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_zero) |=> out_flag);

  // R4
  pos_rd_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_pos) |=> (out_flag == $past(d_pos)));

  // R5
  neg_rd_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_neg) |=> (out_flag == !$past(d_pos)));

  // R7
  rd_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i <= RD_MAX) && (rd_i >= RD_MIN));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(rd_q) && $stable(out_data) && $stable(out_flag)));

endmodule

bind bal_enc bal_enc_chk #(
  .DATA_W (DATA_W),
  .RD_W   (RD_W),
  .RD_MAX (RD_MAX),
  .RD_MIN (RD_MIN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_flag  (out_flag),
  .rd_q      (rd_q)
);

// File: tb/bal_dec.sv
module bal_dec #(
  parameter int DATA_W = 6
) (
  input  logic [DATA_W-1:0] sym_data,
  input  logic              sym_flag,
  output logic [DATA_W-1:0] word
);

  // R10: undo the inversion chosen by the encoder
  assign word = sym_data ^ {DATA_W{sym_flag}};

endmodule

// File: tb/sim_bal_enc.sv
`timescale 1ns/1ps
module sim_bal_enc;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  // 6-bit lane (default parameters)
  logic              rst0 = 1'b1;
  logic signed [3:0] init0 = 4'sd0;
  logic              v0 = 1'b0;
  logic [5:0]        d0 = '0;
  logic              ov0;
  logic [5:0]        od0;
  logic              of0;
  logic [5:0]        rec0;

  // 8-bit lane, where saturation can be reached
  logic              rst1 = 1'b1;
  logic signed [3:0] init1 = 4'sd0;
  logic              v1 = 1'b0;
  logic [7:0]        d1 = '0;
  logic              ov1;
  logic [7:0]        od1;
  logic              of1;

  bal_enc u0 (
    .clk(clk), .rst(rst0), .init_rd(init0), .in_valid(v0), .in_data(d0),
    .out_valid(ov0), .out_data(od0), .out_flag(of0)
  );

  bal_enc #(.DATA_W(8)) u1 (
    .clk(clk), .rst(rst1), .init_rd(init1), .in_valid(v1), .in_data(d1),
    .out_valid(ov1), .out_data(od1), .out_flag(of1)
  );

  bal_dec #(.DATA_W(6)) u_rx (.sym_data(od0), .sym_flag(of0), .word(rec0));

  // {word, expected flag} from rd = 0; the flag sequence follows R3..R6
  localparam logic [6:0] VEC [12] = '{
    {6'b000000, 1'b1}, {6'b111111, 1'b1}, {6'b000111, 1'b0}, {6'b101010, 1'b0},
    {6'b110000, 1'b1}, {6'b000001, 1'b0}, {6'b111100, 1'b0}, {6'b011000, 1'b1},
    {6'b111110, 1'b1}, {6'b001000, 1'b1}, {6'b100000, 1'b0}, {6'b111111, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered and left at a falling edge.
  task automatic reset0(input logic signed [3:0] iv);
    rst0 = 1'b1; init0 = iv; v0 = 1'b0;
    @(negedge clk);
    rst0 = 1'b0;
  endtask

  task automatic reset1(input logic signed [3:0] iv);
    rst1 = 1'b1; init1 = iv; v1 = 1'b0;
    @(negedge clk);
    rst1 = 1'b0;
  endtask

  task automatic step0(input logic v, input logic [5:0] w);
    v0 = v; d0 = w;
    @(negedge clk);
  endtask

  task automatic step1(input logic v, input logic [7:0] w);
    v1 = v; d1 = w;
    @(negedge clk);
  endtask

  initial begin
    int mrd;
    logic mflag;
    logic [5:0] w;
    logic v;
    int dsp;
    @(negedge clk);
    reset0(4'sd0);
    // R8 reset state
    chk("R8 out_valid after reset", int'(ov0), 0);
    chk("R8 out_data after reset", int'(od0), 0);
    chk("R8 out_flag after reset", int'(of0), 0);

    // Vector walk
    for (int i = 0; i < 12; i++) begin
      step0(1'b1, VEC[i][6:1]);
      chk("R1 valid latency", int'(ov0), 1);
      chk("R6 flag sequence", int'(of0), int'(VEC[i][0]));
      chk("R2 data vs flag", int'(od0), int'(VEC[i][6:1] ^ {6{VEC[i][0]}}));
    end
    step0(1'b0, 6'b000000);
    chk("R1 valid drops", int'(ov0), 0);

    // R4: positive start, zero-disparity word stays as it is
    reset0(4'sd3);
    step0(1'b1, 6'b000111);
    chk("R4 rd>0 d=0", int'(of0), 0);
    // R5: negative start, zero-disparity word is inverted
    reset0(-4'sd3);
    step0(1'b1, 6'b000111);
    chk("R5 rd<0 d=0", int'(of0), 1);
    // R3: zero start, positive word still inverted
    reset0(4'sd0);
    step0(1'b1, 6'b111110);
    chk("R3 rd=0 d>0", int'(of0), 1);

    // R8: load -8 is clamped to -6: 000000 -> inv (rd 1), 000111 -> plain
    reset0(-4'sd8);
    step0(1'b1, 6'b000000);
    chk("R8 clamp load first", int'(of0), 1);
    step0(1'b1, 6'b000111);
    chk("R8 clamp load second", int'(of0), 0);

    // R9: idle words are ignored (rd stays 7, so 000111 is sent plain)
    reset0(4'sd0);
    step0(1'b1, 6'b000000);
    step0(1'b0, 6'b000000);
    chk("R9 idle out_valid", int'(ov0), 0);
    chk("R9 idle out_data held", int'(od0), 63);
    chk("R9 idle out_flag held", int'(of0), 1);
    step0(1'b0, 6'b000000);
    step0(1'b1, 6'b000111);
    chk("R9 rd held over idle", int'(of0), 0);

    // R7 upper clamp: 0 + 9 -> 7, then d=0 sent plain
    reset1(4'sd0);
    step1(1'b1, 8'h00);
    chk("R7 upper first", int'(of1), 1);
    step1(1'b1, 8'h0F);
    chk("R7 upper held at +7", int'(of1), 0);
    // R7 lower clamp: 1 - 9 -> -6, +7 -> 1, then d=0 sent plain
    reset1(4'sd1);
    step1(1'b1, 8'h00);
    chk("R7 lower first", int'(of1), 0);
    step1(1'b1, 8'hFF);
    chk("R7 lower second", int'(of1), 0);
    step1(1'b1, 8'h0F);
    chk("R7 lower held at -6", int'(of1), 0);

    // Random traffic against a behavioural model and the decoder
    reset0(4'sd5);
    mrd = 5;
    for (int n = 0; n < 300; n++) begin
      w = 6'($urandom);
      v = ($urandom % 4) != 0;
      step0(v, w);
      chk("R1 random valid", int'(ov0), int'(v));
      if (v) begin
        dsp = 2 * $countones(w) - 6;
        if (mrd == 0) mflag = 1'b1;
        else if (mrd > 0) mflag = (dsp > 0);
        else mflag = !(dsp > 0);
        mrd = mflag ? mrd + 1 - dsp : mrd + dsp - 1;
        if (mrd > 7) mrd = 7;
        if (mrd < -6) mrd = -6;
        chk("R4/R5 random flag", int'(of0), int'(mflag));
        chk("R10 decoder recovers", int'(rec0), int'(w));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule